// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns a single command word from a host into a complete operation on a NAND flash bus. An operation always opens with a command-latch cycle. It can then carry a chosen number of address-latch cycles and a data phase in either direction, and it can close with a second opcode. The opcodes for program-confirm and erase-confirm, and the read-start opcode of large-page parts, all use this second opcode.

The host loads the address, length and second-command inputs and then pulses a write of the command word with its start bit set. The sequencer selects one of two chip enables and holds it active for the whole operation. It paces every bus cycle with fixed low and high strobe widths. Write data is pulled from a byte FIFO and read data is pushed into another byte FIFO.

Completion is reported through a small interrupt status register whose bits the host clears by writing ones. A write or data-less operation is finished when the command-done bit sets. A read is finished only when the data-done bit sets, because its data is fetched after the flash reports ready.

Top module: `nand_cmd_seq`

## Requirements
- R1: A command is accepted only when `cmd_wr` is pulsed with `cmd_word[31]` set. With bit 31 clear, no bus cycle occurs and no status bit sets. After reset the chip enables, WE# and RE# are high, CLE and ALE are low, and `irq_status` is zero.
- R2: The first bus cycle of every operation is a WE# pulse with CLE high, carrying `cmd_word[7:0]`.
- R3: When `cmd_word[30]` is set, `cmd_word[29:27]`+1 ALE cycles follow the first command. They send the bytes of {`addr2`, `addr1`} least significant byte first, and any byte past the fifth is zero. With bit 30 clear there are no address cycles.
- R4: `cmd_word[19]` low selects `nand_ce_n[0]`, high selects `nand_ce_n[1]`. The selected enable is low for every bus cycle of the operation, and the other enable stays high.
- R5: With `cmd_word[25]` set and bit 26 clear, `data_len` bytes are popped from the transmit FIFO and written with WE# pulses (CLE and ALE low) after the address cycles. The sequencer waits while the FIFO is empty.
- R6: With `cmd_word[26]` set, which wins over bit 25, `data_len` RE# cycles run after the flash reports ready. Each sampled byte is pushed to the receive FIFO in order, and the sequencer waits while the FIFO is full. DQ is never driven during RE# low.
- R7: When `cmd2_word[8]` is set, a CLE cycle carrying `cmd2_word[7:0]` is issued. For write and data-less operations it comes after the data phase. For reads it comes after the address cycles and before the ready wait.
- R8: Command-done (`irq_status[31]`) sets only after a fixed delay following the last command cycle, and only once `nand_rb` is high. It stays clear while `nand_rb` is low.
- R9: Data-done (`irq_status[28]`) sets when the data phase ends, including a zero-length phase, which produces no strobes. For a read with a non-zero length it sets after command-done. A data-less operation never sets it.
- R10: Writing `irq_wr` with a one in bit 31 or bit 28 of `irq_wdata` clears that status bit. Zeros leave bits unchanged, and all other status bits read zero.
- R11: A command word written while an operation is in progress is ignored. The running operation is unchanged and nothing extra follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Host write strobe for the command word |
| cmd_word | input | 32 | Start, address field, direction, chip select, first opcode |
| cmd2_word | input | 32 | Second-opcode enable (bit 8) and opcode (7:0) |
| addr1 | input | 16 | Column or low page address bytes |
| addr2 | input | 24 | Upper page address bytes |
| data_len | input | 16 | Data phase length in bytes |
| irq_wr | input | 1 | Host write strobe for status clear |
| irq_wdata | input | 32 | Write-one-to-clear mask |
| irq_status | output | 32 | Status: bit 31 command done, bit 28 data done |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 2 | Chip enables, active low |
| nand_dq_out | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus in |
| nand_rb | input | 1 | Ready (high) / busy (low) |
| txf_data | input | 8 | Transmit FIFO head byte |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_pop | output | 1 | Transmit FIFO pop |
| rxf_data | output | 8 | Receive FIFO write byte |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_push | output | 1 | Receive FIFO push |

## Verification
Every bus cycle takes four clocks: one launch clock, two clocks with the strobe low and one with it high. The bench logs each WE# rising edge together with CLE, ALE, DQ and the enables. It compares that log only after the completion bit is seen, so the exact cycle count is not part of the comparison. Status bits are registered one clock after their condition. The bench polls them at falling edges with a bounded wait and then checks the other bit at that same instant; this gives the ordering checks (data-done clear when command-done rises on a read). Checks that something does not happen use windows of 50 to 100 clocks, much longer than any single bus cycle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int BIT_GO     = 31;
    localparam int BIT_AEN    = 30;
    localparam int BIT_AN_HI  = 29;
    localparam int BIT_AN_LO  = 27;
    localparam int BIT_RD     = 26;
    localparam int BIT_WR     = 25;
    localparam int BIT_CS     = 19;
    localparam int BIT_C2EN   = 8;
    localparam int IRQ_CMD    = 31;
    localparam int IRQ_DATA   = 28;

    typedef enum logic [1:0] {
        BUS_CMD,
        BUS_ADDR,
        BUS_WDATA,
        BUS_RDATA
    } bus_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD1,
        SQ_ADDR,
        SQ_WDATA,
        SQ_CMD2,
        SQ_TWB,
        SQ_WAITRB,
        SQ_RDATA
    } seq_state_e;

    typedef struct packed {
        logic       chip;
        logic       rd;
        logic       wr;
        logic       addr_en;
        logic [2:0] addr_n;
        logic [7:0] op1;
        logic       c2_en;
        logic [7:0] op2;
    } op_t;

    function automatic op_t decode_op(input logic [31:0] w1, input logic [31:0] w2);
        op_t o;
        o.chip    = w1[BIT_CS];
        o.rd      = w1[BIT_RD];
        o.wr      = w1[BIT_WR] & ~w1[BIT_RD];
        o.addr_en = w1[BIT_AEN];
        o.addr_n  = w1[BIT_AN_HI:BIT_AN_LO];
        o.op1     = w1[7:0];
        o.c2_en   = w2[BIT_C2EN];
        o.op2     = w2[7:0];
        return o;
    endfunction

endpackage

// File: rtl/nand_bus_phy.sv
module nand_bus_phy
    import nand_seq_pkg::*;
#(
    parameter int LO_CYC = 2,
    parameter int HI_CYC = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  bus_kind_e  kind,
    input  logic [7:0] byte_in,
    input  logic [7:0] dq_in,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic       dq_oe,
    output logic [7:0] dq_out,
    output logic       done,
    output logic       rd_push,
    output logic [7:0] rd_byte
);
    localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;

    ph_e        ph;
    bus_kind_e  k;
    logic [7:0] b;
    logic [CW-1:0] cnt;
    logic lo_last, hi_last, active;

    assign lo_last = (ph == PH_LOW)  && (cnt == CW'(LO_CYC - 1));
    assign hi_last = (ph == PH_HIGH) && (cnt == CW'(HI_CYC - 1));
    assign active  = (ph != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
            k   <= BUS_CMD;
            b   <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (start) begin
                    ph  <= PH_LOW;
                    cnt <= '0;
                    k   <= kind;
                    b   <= byte_in;
                end
                PH_LOW: if (lo_last) begin
                    ph  <= PH_HIGH;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_HIGH: if (hi_last) begin
                    ph  <= PH_IDLE;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        cle     = active && (k == BUS_CMD);
        ale     = active && (k == BUS_ADDR);
        dq_oe   = active && (k != BUS_RDATA);
        we_n    = !((ph == PH_LOW) && (k != BUS_RDATA));
        re_n    = !((ph == PH_LOW) && (k == BUS_RDATA));
        dq_out  = b;
        done    = hi_last;
        rd_push = lo_last && (k == BUS_RDATA);
        rd_byte = dq_in;
    end

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
    import nand_seq_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int A1_W    = 16,
    parameter int A2_W    = 24,
    parameter int TWB_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [31:0]      cmd_word,
    input  logic [31:0]      cmd2_word,
    input  logic [A1_W-1:0]  addr1,
    input  logic [A2_W-1:0]  addr2,
    input  logic [LEN_W-1:0] data_len,
    input  logic             nand_rb,
    input  logic             txf_empty,
    input  logic [7:0]       txf_data,
    output logic             txf_pop,
    input  logic             rxf_full,
    input  logic             phy_done,
    output logic             phy_start,
    output bus_kind_e        phy_kind,
    output logic [7:0]       phy_byte,
    output logic [1:0]       ce_n,
    output logic             set_cmd,
    output logic             set_data
);
    localparam int AW = A1_W + A2_W;
    localparam int TW = $clog2(TWB_CYC + 1);

    seq_state_e       st;
    op_t              op;
    logic [AW-1:0]    areg;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] bcnt;
    logic [2:0]       acnt;
    logic [TW-1:0]    tcnt;
    logic             inflight;
    logic             can_go;
    logic             data_end;
    seq_state_e       after_addr;
    seq_state_e       after_data;

    always_comb begin
        after_data = op.c2_en ? SQ_CMD2 : SQ_TWB;
        after_addr = op.wr ? SQ_WDATA : after_data;
        can_go     = 1'b0;
        phy_kind   = BUS_CMD;
        phy_byte   = op.op1;
        unique case (st)
            SQ_CMD1: can_go = 1'b1;
            SQ_ADDR: begin
                can_go   = 1'b1;
                phy_kind = BUS_ADDR;
                phy_byte = 8'(areg >> {acnt, 3'b000});
            end
            SQ_WDATA: begin
                can_go   = (bcnt != len_q) && !txf_empty;
                phy_kind = BUS_WDATA;
                phy_byte = txf_data;
            end
            SQ_CMD2: begin
                can_go   = 1'b1;
                phy_byte = op.op2;
            end
            SQ_RDATA: begin
                can_go   = (bcnt != len_q) && !rxf_full;
                phy_kind = BUS_RDATA;
                phy_byte = 8'h00;
            end
            default: can_go = 1'b0;
        endcase
    end

    assign phy_start = can_go && !inflight;
    assign txf_pop   = phy_start && (st == SQ_WDATA);
    assign data_end  = ((st == SQ_WDATA) || (st == SQ_RDATA)) && !inflight && (bcnt == len_q);
    assign set_data  = data_end;
    assign set_cmd   = (st == SQ_WAITRB) && nand_rb;
    assign ce_n      = (st == SQ_IDLE) ? 2'b11 : (op.chip ? 2'b01 : 2'b10);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            op       <= '0;
            areg     <= '0;
            len_q    <= '0;
            bcnt     <= '0;
            acnt     <= '0;
            tcnt     <= '0;
            inflight <= 1'b0;
        end else begin
            if (phy_start)
                inflight <= 1'b1;
            else if (phy_done)
                inflight <= 1'b0;

            if (st != SQ_TWB)
                tcnt <= '0;

            unique case (st)
                SQ_IDLE: if (cmd_wr && cmd_word[BIT_GO]) begin
                    op    <= decode_op(cmd_word, cmd2_word);
                    areg  <= {addr2, addr1};
                    len_q <= data_len;
                    bcnt  <= '0;
                    acnt  <= '0;
                    st    <= SQ_CMD1;
                end
                SQ_CMD1: if (phy_done)
                    st <= op.addr_en ? SQ_ADDR : after_addr;
                SQ_ADDR: if (phy_done) begin
                    if (acnt == op.addr_n)
                        st <= after_addr;
                    else
                        acnt <= acnt + 1'b1;
                end
                SQ_WDATA: begin
                    if (phy_done)
                        bcnt <= bcnt + 1'b1;
                    if (data_end)
                        st <= after_data;
                end
                SQ_CMD2: if (phy_done)
                    st <= SQ_TWB;
                SQ_TWB: begin
                    if (tcnt == TW'(TWB_CYC - 1))
                        st <= SQ_WAITRB;
                    else
                        tcnt <= tcnt + 1'b1;
                end
                SQ_WAITRB: if (nand_rb) begin
                    bcnt <= '0;
                    st   <= op.rd ? SQ_RDATA : SQ_IDLE;
                end
                SQ_RDATA: begin
                    if (phy_done)
                        bcnt <= bcnt + 1'b1;
                    if (data_end)
                        st <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nand_irq_stat.sv
module nand_irq_stat
    import nand_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        set_cmd,
    input  logic        set_data,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic [31:0] status
);
    logic cmd_b, data_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_b  <= 1'b0;
            data_b <= 1'b0;
        end else begin
            cmd_b  <= set_cmd  | (cmd_b  & ~(wr & wdata[IRQ_CMD]));
            data_b <= set_data | (data_b & ~(wr & wdata[IRQ_DATA]));
        end
    end

    always_comb begin
        status           = '0;
        status[IRQ_CMD]  = cmd_b;
        status[IRQ_DATA] = data_b;
    end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int A1_W    = 16,
    parameter int A2_W    = 24,
    parameter int TWB_CYC = 4,
    parameter int STB_LO  = 2,
    parameter int STB_HI  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [31:0]      cmd_word,
    input  logic [31:0]      cmd2_word,
    input  logic [A1_W-1:0]  addr1,
    input  logic [A2_W-1:0]  addr2,
    input  logic [LEN_W-1:0] data_len,
    input  logic             irq_wr,
    input  logic [31:0]      irq_wdata,
    output logic [31:0]      irq_status,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [1:0]       nand_ce_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb,
    input  logic [7:0]       txf_data,
    input  logic             txf_empty,
    output logic             txf_pop,
    output logic [7:0]       rxf_data,
    input  logic             rxf_full,
    output logic             rxf_push
);
    logic       phy_start, phy_done;
    bus_kind_e  phy_kind;
    logic [7:0] phy_byte;
    logic       set_cmd_w, set_data_w;

    nand_seq_ctrl #(
        .LEN_W(LEN_W), .A1_W(A1_W), .A2_W(A2_W), .TWB_CYC(TWB_CYC)
    ) u_ctrl (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .cmd2_word(cmd2_word), .addr1(addr1), .addr2(addr2), .data_len(data_len),
        .nand_rb(nand_rb), .txf_empty(txf_empty), .txf_data(txf_data),
        .txf_pop(txf_pop), .rxf_full(rxf_full), .phy_done(phy_done),
        .phy_start(phy_start), .phy_kind(phy_kind), .phy_byte(phy_byte),
        .ce_n(nand_ce_n), .set_cmd(set_cmd_w), .set_data(set_data_w)
    );

    nand_bus_phy #(
        .LO_CYC(STB_LO), .HI_CYC(STB_HI)
    ) u_phy (
        .clk(clk), .rst(rst), .start(phy_start), .kind(phy_kind),
        .byte_in(phy_byte), .dq_in(nand_dq_in), .cle(nand_cle), .ale(nand_ale),
        .we_n(nand_we_n), .re_n(nand_re_n), .dq_oe(nand_dq_oe),
        .dq_out(nand_dq_out), .done(phy_done), .rd_push(rxf_push),
        .rd_byte(rxf_data)
    );

    nand_irq_stat u_irq (
        .clk(clk), .rst(rst), .set_cmd(set_cmd_w), .set_data(set_data_w),
        .wr(irq_wr), .wdata(irq_wdata), .status(irq_status)
    );

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        cle,
    input logic        ale,
    input logic        we_n,
    input logic        re_n,
    input logic        dq_oe,
    input logic [1:0]  ce_n,
    input logic        rb,
    input logic [31:0] irq_status,
    input logic        irq_wr,
    input logic [31:0] irq_wdata,
    input logic        set_cmd,
    input logic        set_data,
    input logic        txf_pop,
    input logic        txf_empty,
    input logic        rxf_push,
    input logic        rxf_full
);
    // R4: never both chip enables active
    a_r4_one_ce: assert property (@(posedge clk) disable iff (rst)
        $countones(~ce_n) <= 1);

    // R2/R3: command and address latch never together
    a_r3_cle_ale_excl: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    // R6: bus not driven during a read strobe; strobes exclusive
    a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> (!dq_oe && we_n));

    // R8: command done only with ready seen on the previous cycle
    a_r8_done_needs_rb: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_status[31]) |-> $past(rb));

    // R5: pops only from a non-empty FIFO and only inside an operation
    a_r5_pop_ok: assert property (@(posedge clk) disable iff (rst)
        txf_pop |-> (!txf_empty && (ce_n != 2'b11)));

    // R6: pushes only into a non-full FIFO
    a_r6_push_ok: assert property (@(posedge clk) disable iff (rst)
        rxf_push |-> !rxf_full);

    // R10: write-one-to-clear takes effect on the next cycle
    a_r10_w1c_cmd: assert property (@(posedge clk) disable iff (rst)
        (irq_wr && irq_wdata[31] && !set_cmd) |=> !irq_status[31]);
    a_r10_w1c_data: assert property (@(posedge clk) disable iff (rst)
        (irq_wr && irq_wdata[28] && !set_data) |=> !irq_status[28]);

    // R10: unimplemented status bits stay zero
    a_r10_spare_zero: assert property (@(posedge clk) disable iff (rst)
        (irq_status & ~32'h9000_0000) == 32'h0);

endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
    .clk(clk), .rst(rst), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .dq_oe(nand_dq_oe), .ce_n(nand_ce_n), .rb(nand_rb),
    .irq_status(irq_status), .irq_wr(irq_wr), .irq_wdata(irq_wdata),
    .set_cmd(set_cmd_w), .set_data(set_data_w), .txf_pop(txf_pop),
    .txf_empty(txf_empty), .rxf_push(rxf_push), .rxf_full(rxf_full)
);

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] cmd2_word = '0;
    logic [15:0] addr1 = 16'hB2A1;
    logic [23:0] addr2 = 24'hE5D4C3;
    logic [15:0] data_len = '0;
    logic        irq_wr = 1'b0;
    logic [31:0] irq_wdata = '0;
    logic [31:0] irq_status;
    logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [1:0] nand_ce_n;
    logic [7:0] nand_dq_out, nand_dq_in;
    logic nand_rb = 1'b1;
    logic [7:0] txf_data, rxf_data;
    logic txf_empty, txf_pop, rxf_push;
    logic rxf_full = 1'b0;

    always #2.5 clk = ~clk;

    nand_cmd_seq u_dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .cmd2_word(cmd2_word), .addr1(addr1), .addr2(addr2), .data_len(data_len),
        .irq_wr(irq_wr), .irq_wdata(irq_wdata), .irq_status(irq_status),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb),
        .txf_data(txf_data), .txf_empty(txf_empty), .txf_pop(txf_pop),
        .rxf_data(rxf_data), .rxf_full(rxf_full), .rxf_push(rxf_push)
    );

    int n_chk = 0, n_fail = 0;
    bit fin = 0, log_en = 0;

    // transmit FIFO model
    logic [7:0] txq [0:255];
    int txw = 0, txr = 0, tx_seq = 0;
    assign txf_data  = txq[txr & 255];
    assign txf_empty = (txr == txw);
    always @(posedge clk) if (txf_pop) txr <= txr + 1;

    // flash read data model and receive FIFO model
    int rd_idx = 0;
    assign nand_dq_in = 8'h50 + 8'(rd_idx);
    always @(posedge nand_re_n) if (log_en) rd_idx <= rd_idx + 1;
    logic [7:0] rxq [0:1023];
    int rx_n = 0;
    always @(posedge clk) if (rxf_push) begin rxq[rx_n & 1023] <= rxf_data; rx_n <= rx_n + 1; end

    // write-strobe log: {cle, ale, ce_n, byte}
    logic [11:0] lg [0:1023];
    int lg_n = 0;
    always @(posedge nand_we_n) if (log_en) begin
        lg[lg_n & 1023] = {nand_cle, nand_ale, nand_ce_n, nand_dq_out};
        lg_n = lg_n + 1;
    end

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input bit go, input bit aen, input int an,
        input bit rd, input bit wr, input bit cs, input logic [7:0] op);
        logic [31:0] w = '0;
        w[31] = go; w[30] = aen; w[29:27] = 3'(an); w[26] = rd; w[25] = wr;
        w[19] = cs; w[7:0] = op;
        return w;
    endfunction

    task automatic issue(input logic [31:0] w, input logic [31:0] w2, input int len);
        @(negedge clk);
        cmd_word = w; cmd2_word = w2; data_len = 16'(len); cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_bit(input int idx, output bit ok);
        ok = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (irq_status[idx]) begin ok = 1; break; end
        end
    endtask

    task automatic push_tx(input int n);
        for (int i = 0; i < n; i++) begin
            txq[txw & 255] = 8'hC0 + 8'(tx_seq);
            tx_seq++; txw++;
        end
    endtask

    task automatic clear_all();
        @(negedge clk); irq_wr = 1; irq_wdata = 32'hFFFF_FFFF;
        @(negedge clk); irq_wr = 0; irq_wdata = 0;
        @(negedge clk);
        chk(irq_status == 0, "R10 clear all", irq_status, 0);
    endtask

    task automatic run_op(input bit aen, input int an, input bit rd, input bit wr,
        input bit cs, input bit c2, input int len, input logic [7:0] op1,
        input logic [7:0] op2, input bit inject);
        logic [31:0] w;
        logic [39:0] av;
        logic [9:0] ex [0:31];
        int nexp = 0, l0, r0, x0, t0, got, bad2 = 0, bad3 = 0, bad5 = 0, bad7 = 0, bad4 = 0, bad6 = 0;
        bit ok, isrd, iswr;
        logic [1:0] ece;
        w = mk_cmd(1, aen, an, rd, wr, cs, op1);
        isrd = rd; iswr = wr && !rd;
        av = {addr2, addr1};
        ece = cs ? 2'b01 : 2'b10;
        t0 = tx_seq;
        if (iswr) push_tx(len);
        l0 = lg_n; r0 = rx_n; x0 = rd_idx;
        ex[nexp++] = {2'b10, op1};
        if (aen) for (int j = 0; j <= an; j++) ex[nexp++] = {2'b01, (j < 5) ? 8'(av >> (8*j)) : 8'h00};
        if (iswr) for (int j = 0; j < len; j++) ex[nexp++] = {2'b00, 8'hC0 + 8'(t0 + j)};
        if (c2) ex[nexp++] = {2'b10, op2};
        issue(w, {23'b0, c2, op2}, len);
        if (inject) begin
            repeat (5) @(negedge clk);
            cmd_word = mk_cmd(1, 0, 0, 0, 0, !cs, 8'hEE); cmd_wr = 1;
            @(negedge clk); cmd_wr = 0;
        end
        wait_bit(31, ok);
        chk(ok, "R8 command done seen", ok, 1);
        if (isrd) begin
            if (len > 0) chk(!irq_status[28], "R9 read data-done after command-done", irq_status[28], 0);
            wait_bit(28, ok);
            chk(ok, "R9 read data-done seen", ok, 1);
        end else begin
            repeat (3) @(negedge clk);
            chk(irq_status[28] == iswr, "R9 data-done per direction", irq_status[28], iswr);
        end
        if (inject) repeat (60) @(negedge clk);
        got = lg_n - l0;
        chk(got == nexp, "R3 write-strobe cycle count", got, nexp);
        for (int j = 0; j < nexp && j < got; j++) begin
            logic [11:0] e;
            e = lg[(l0 + j) & 1023];
            if (e[7:0] != ex[j][7:0] || e[11:10] != ex[j][9:8]) begin
                if (j == 0) bad2++;
                else if (ex[j][9:8] == 2'b01) bad3++;
                else if (ex[j][9:8] == 2'b00) bad5++;
                else bad7++;
            end
            if (e[9:8] != ece) bad4++;
        end
        chk(bad2 == 0, "R2 first command cycle", bad2, 0);
        chk(bad3 == 0, "R3 address bytes", bad3, 0);
        if (iswr) chk(bad5 == 0, "R5 write data bytes", bad5, 0);
        if (c2) chk(bad7 == 0, "R7 second opcode", bad7, 0);
        chk(bad4 == 0, "R4 chip enable", bad4, 0);
        if (inject) chk(got == nexp, "R11 injected command ignored", got, nexp);
        got = rx_n - r0;
        chk(got == (isrd ? len : 0), "R6 read byte count", got, isrd ? len : 0);
        if (isrd) begin
            for (int j = 0; j < len && j < got; j++)
                if (rxq[(r0 + j) & 1023] != 8'h50 + 8'(x0 + j)) bad6++;
            chk(bad6 == 0, "R6 read bytes in order", bad6, 0);
        end
        clear_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit ok;
        int l0, r0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        log_en = 1;
        // R1 reset state
        chk(irq_status == 0, "R1 reset status", irq_status, 0);
        chk(nand_ce_n == 2'b11, "R1 reset chip enables", nand_ce_n, 3);
        chk({nand_we_n, nand_re_n, nand_cle, nand_ale} == 4'b1100, "R1 reset strobes",
            {nand_we_n, nand_re_n, nand_cle, nand_ale}, 4'b1100);

        // R1 start bit clear is ignored
        l0 = lg_n;
        issue(mk_cmd(0, 1, 2, 0, 1, 0, 8'h80), 32'h110, 2);
        repeat (60) @(negedge clk);
        chk(lg_n == l0, "R1 no bus cycle without start bit", lg_n - l0, 0);
        chk(irq_status == 0, "R1 no status without start bit", irq_status, 0);

        // near-exhaustive sweep over address field, direction, length, second opcode
        for (int ai = 0; ai < 9; ai++)
            for (int m = 0; m < 3; m++)
                for (int c2 = 0; c2 < 2; c2++)
                    for (int li = 0; li < 2; li++)
                        run_op(ai < 8, (ai < 8) ? ai : 0, m == 2, m == 1, (ai + m) % 2 == 1,
                               c2 == 1, li * 3, 8'h10 + 8'(ai * 6 + m * 2 + c2),
                               8'hD0 + 8'(ai), 0);

        // R6 read bit wins over write bit
        run_op(1, 0, 1, 1, 0, 1, 2, 8'h00, 8'h30, 0);

        // R11 command written during an operation
        run_op(1, 1, 0, 1, 1, 1, 1, 8'h80, 8'h10, 1);

        // R8 ready/busy held low
        nand_rb = 0;
        l0 = lg_n;
        issue(mk_cmd(1, 0, 0, 0, 0, 0, 8'hFF), 32'h0, 0);
        repeat (100) @(negedge clk);
        chk(!irq_status[31], "R8 no done while busy", irq_status[31], 0);
        chk(lg_n - l0 == 1, "R2 command issued before busy wait", lg_n - l0, 1);
        nand_rb = 1;
        wait_bit(31, ok);
        chk(ok, "R8 done after ready", ok, 1);
        clear_all();

        // R5 stall on empty transmit FIFO
        l0 = lg_n;
        issue(mk_cmd(1, 1, 0, 0, 1, 0, 8'h85), 32'h0, 2);
        repeat (100) @(negedge clk);
        chk(lg_n - l0 == 2, "R5 waits while FIFO empty", lg_n - l0, 2);
        push_tx(2);
        wait_bit(31, ok);
        chk(ok && (lg_n - l0 == 4), "R5 completes after fill", lg_n - l0, 4);
        chk(lg[(l0 + 3) & 1023][7:0] == 8'hC0 + 8'(tx_seq - 1), "R5 last byte after stall",
            lg[(l0 + 3) & 1023][7:0], 8'hC0 + 8'(tx_seq - 1));
        clear_all();

        // R6 stall on full receive FIFO, then R10 partial clear
        rxf_full = 1;
        r0 = rx_n;
        issue(mk_cmd(1, 0, 0, 1, 0, 1, 8'h90), 32'h0, 2);
        wait_bit(31, ok);
        repeat (50) @(negedge clk);
        chk(rx_n == r0, "R6 no push while full", rx_n - r0, 0);
        chk(!irq_status[28], "R9 no data-done while stalled", irq_status[28], 0);
        rxf_full = 0;
        wait_bit(28, ok);
        chk(ok && (rx_n - r0 == 2), "R6 bytes after release", rx_n - r0, 2);
        @(negedge clk); irq_wr = 1; irq_wdata = 32'h8000_0000;
        @(negedge clk); irq_wr = 0;
        @(negedge clk);
        chk(irq_status == 32'h1000_0000, "R10 clear command bit only", irq_status, 32'h1000_0000);
        @(negedge clk); irq_wr = 1; irq_wdata = 32'h0;
        @(negedge clk); irq_wr = 0;
        @(negedge clk);
        chk(irq_status == 32'h1000_0000, "R10 zero write keeps bits", irq_status, 32'h1000_0000);
        @(negedge clk); irq_wr = 1; irq_wdata = 32'h1000_0000;
        @(negedge clk); irq_wr = 0;
        @(negedge clk);
        chk(irq_status == 0, "R10 clear data bit", irq_status, 0);

        fin = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule